// File: doc/BRIEF.md
# Virtual Tributary Circuit Emulation Packetizer

This block turns the byte stream of a single virtual tributary into fixed-size circuit emulation packets. Each packet is a 32-bit emulation header followed by a configured number of payload bytes. The block is fed one byte per handshake, together with a marker on the first overhead byte of every multiframe (V1) and a marker on the path overhead byte V5. It counts the multiframe into quarters to find the four overhead bytes V1 to V4.

In structured mode the four overhead bytes are dropped from the payload. The header pointer then gives the payload offset of V5. Pointer adjustment events and path AIS go into two header flags. In unstructured mode every byte is carried, and the pointer gives the payload offset of V1. In both modes the pointer is 0x1FF when the packet does not hold the byte it tracks. A 14-bit sequence number is stamped into each packet. The remote defect and bandwidth flags copy request inputs.

The payload is gathered in a buffer until the packet is complete, so the pointer is known before the header goes out. The header and payload then leave on a byte-wide valid/ready port with a last-byte marker. No input is taken while a packet is being sent.

Top module: `vt_ce_packetizer`

## Requirements
- R1: A packet leaves as four header bytes, most significant first, then the payload bytes in arrival order. Header bit 31 is 0, bit 30 is the remote defect flag, bit 29 is the bandwidth flag, bit 28 is N, bit 27 is P, bits 26..14 are the pointer and bits 13..0 are the sequence number.
- R2: `cfg_vt_kind` 0, 1, 2, 3 selects 108, 144, 216 or 432 bytes per multiframe. The byte flagged by `in_mf_start` is V1. The multiframe splits into four equal quarters counted from V1, and the first byte of each quarter is an overhead byte.
- R3: In structured mode (`cfg_structured`=1) overhead bytes are not carried. The pointer is the payload offset (0 = first byte after the header) of the first carried byte flagged by `in_v5`, or 0x1FF if there is none.
- R4: In unstructured mode every byte is carried and `in_v5` is ignored. The pointer is the payload offset of V1, or 0x1FF if there is none.
- R5: The payload length is valid from 1 up to the multiframe size, minus 4 in structured mode. An invalid length raises `cfg_err`, and input bytes are then accepted and discarded, with no packet produced.
- R6: `evt_ptr_dec` sets N and `evt_ptr_inc` sets P. `evt_ais` sets both. Events gather until the next packet is sealed and then clear. An unstructured packet always has N=P=0.
- R7: The remote defect and bandwidth flags equal `rdi_req` and `dba_req` in the cycle the packet's last payload byte is accepted.
- R8: The sequence number is 0 for the first packet after reset, rises by one per packet and wraps modulo 2^14.
- R9: After reset, bytes that arrive before the first `in_mf_start` are discarded.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `out_last` marks the final payload byte. `in_ready` stays low from the packet's last accepted input byte until its last output byte is taken.
- R11: Out of reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vt_kind | input | 2 | Tributary size select (0..3) |
| cfg_structured | input | 1 | 1 = structured, 0 = unstructured |
| cfg_payload_len | input | 9 | Payload bytes per packet |
| cfg_err | output | 1 | Payload length not allowed for the kind and mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block takes a byte |
| in_data | input | 8 | Tributary byte |
| in_mf_start | input | 1 | This byte is V1 |
| in_v5 | input | 1 | This byte is V5 |
| evt_ptr_dec | input | 1 | Negative pointer adjustment seen |
| evt_ptr_inc | input | 1 | Positive pointer adjustment seen |
| evt_ais | input | 1 | Path AIS seen |
| rdi_req | input | 1 | Remote defect to signal |
| dba_req | input | 1 | Bandwidth flag to signal |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Header or payload byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
Streams for all four tributary sizes are run in both modes. The payload lengths are chosen so that some packets span a whole multiframe, some hold no tracked byte and some hold it at varied offsets. These runs separate the overhead stripping and the pointer arithmetic from plain byte copying. The same streams run against steady, alternating and sparse sink readiness, which shows that backpressure changes neither content nor order. Directed runs pulse each pointer event in each mode to tell flag gathering from flag clearing, and probe lengths just inside and outside the limit. A long run of one-byte packets carries the sequence number across its wrap.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

  localparam int LEN_W     = 9;
  localparam int PTR_W     = 13;
  localparam int SEQ_W     = 14;
  localparam int HDR_BYTES = 4;
  localparam logic [PTR_W-1:0] PTR_NONE = 13'h1FF;

  typedef enum logic [1:0] {
    VT_1P5 = 2'd0,
    VT_2   = 2'd1,
    VT_3   = 2'd2,
    VT_6   = 2'd3
  } vt_kind_e;

  typedef struct packed {
    logic             zero;
    logic             rdi;
    logic             dba;
    logic             neg;
    logic             pos;
    logic [PTR_W-1:0] ptr;
    logic [SEQ_W-1:0] seq;
  } emu_hdr_t;

  // bytes in one multiframe of the tributary
  function automatic logic [LEN_W-1:0] mf_bytes(input vt_kind_e k);
    case (k)
      VT_1P5:  return 9'd108;
      VT_2:    return 9'd144;
      VT_3:    return 9'd216;
      default: return 9'd432;
    endcase
  endfunction

  // one quarter of the multiframe: one overhead byte leads each quarter
  function automatic logic [LEN_W-1:0] quarter_bytes(input vt_kind_e k);
    return mf_bytes(k) >> 2;
  endfunction

  // largest payload for a packet: structured mode drops the four overhead bytes
  function automatic logic [LEN_W-1:0] max_payload(input vt_kind_e k, input logic structured);
    return mf_bytes(k) - (structured ? 9'd4 : 9'd0);
  endfunction

  function automatic logic len_allowed(input vt_kind_e k, input logic structured,
                                       input logic [LEN_W-1:0] len, input int buf_depth);
    return (len != '0) && (len <= max_payload(k, structured)) && (int'(len) <= buf_depth);
  endfunction

  // header byte sel (0 = most significant)
  function automatic logic [7:0] hdr_byte(input emu_hdr_t h, input logic [1:0] sel);
    logic [31:0] w;
    w = h;
    return 8'(w >> (8 * (3 - int'(sel))));
  endfunction

endpackage

// File: rtl/vtp_mf_tracker.sv
module vtp_mf_tracker
  import vtp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  vt_kind_e vt_kind,
  input  logic     beat,
  input  logic     mf_start,
  output logic     byte_synced,
  output logic     is_ovh,
  output logic     is_v1
);

  logic             synced_q;
  logic [LEN_W-1:0] seg_pos_q;
  logic [1:0]       seg_idx_q;
  logic [LEN_W-1:0] quarter;
  logic [LEN_W-1:0] cur_pos;
  logic [1:0]       cur_seg;
  logic             seg_wrap;

  assign quarter     = quarter_bytes(vt_kind);
  assign cur_pos     = mf_start ? '0 : seg_pos_q;
  assign cur_seg     = mf_start ? 2'd0 : seg_idx_q;
  assign byte_synced = synced_q | mf_start;
  assign is_ovh      = byte_synced && (cur_pos == '0);
  assign is_v1       = is_ovh && (cur_seg == 2'd0);
  assign seg_wrap    = (cur_pos >= quarter - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q  <= 1'b0;
      seg_pos_q <= '0;
      seg_idx_q <= 2'd0;
    end else if (beat && byte_synced) begin
      synced_q <= 1'b1;
      if (seg_wrap) begin
        seg_pos_q <= '0;
        seg_idx_q <= cur_seg + 2'd1;
      end else begin
        seg_pos_q <= cur_pos + 1'b1;
        seg_idx_q <= cur_seg;
      end
    end
  end

  AST_MF_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mf_start) |=> (seg_pos_q == 9'd1) && (seg_idx_q == 2'd0)); // R2

  AST_SYNC_ONLY_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced_q) |-> $past(beat && mf_start)); // R9

endmodule

// File: rtl/vtp_collector.sv
module vtp_collector
  import vtp_pkg::*;
#(
  parameter int MAX_BUF = 432,
  parameter int BUF_AW  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_structured,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_ok,
  input  logic             beat,
  input  logic [7:0]       in_data,
  input  logic             byte_synced,
  input  logic             is_ovh,
  input  logic             is_v1,
  input  logic             is_v5,
  input  logic             ev_neg,
  input  logic             ev_pos,
  input  logic             ev_ais,
  input  logic             rdi_req,
  input  logic             dba_req,
  input  logic             release_i,
  input  logic [LEN_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             sealed,
  output logic             store_en,
  output logic             seal_evt,
  output logic             hdr_rdi,
  output logic             hdr_dba,
  output logic             hdr_neg,
  output logic             hdr_pos,
  output logic [PTR_W-1:0] hdr_ptr
);

  logic [7:0]       buf_q [MAX_BUF];
  logic [LEN_W-1:0] fill_q;
  logic             found_q;
  logic [PTR_W-1:0] ptr_q;
  logic             neg_acc_q;
  logic             pos_acc_q;
  logic             mark_hit;
  logic             ev_n;
  logic             ev_p;

  assign store_en = beat && byte_synced && cfg_ok && !(cfg_structured && is_ovh);
  assign mark_hit = cfg_structured ? (is_v5 && !is_ovh) : is_v1;
  assign seal_evt = store_en && (fill_q == cfg_len - 1'b1);
  assign ev_n     = ev_neg | ev_ais;
  assign ev_p     = ev_pos | ev_ais;
  assign rd_data  = buf_q[BUF_AW'(rd_idx)];

  always_ff @(posedge clk) begin
    if (store_en) buf_q[BUF_AW'(fill_q)] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sealed  <= 1'b0;
      fill_q  <= '0;
      found_q <= 1'b0;
      ptr_q   <= PTR_NONE;
      hdr_ptr <= PTR_NONE;
      hdr_rdi <= 1'b0;
      hdr_dba <= 1'b0;
    end else begin
      if (release_i) sealed <= 1'b0;
      if (seal_evt) begin
        sealed  <= 1'b1;
        fill_q  <= '0;
        found_q <= 1'b0;
        ptr_q   <= PTR_NONE;
        hdr_ptr <= found_q ? ptr_q : (mark_hit ? PTR_W'(fill_q) : PTR_NONE);
        hdr_rdi <= rdi_req;
        hdr_dba <= dba_req;
      end else if (store_en) begin
        fill_q <= fill_q + 1'b1;
        if (mark_hit && !found_q) begin
          found_q <= 1'b1;
          ptr_q   <= PTR_W'(fill_q);
        end
      end
    end
  end

  // pointer events gather until a packet is sealed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_acc_q <= 1'b0;
      pos_acc_q <= 1'b0;
      hdr_neg   <= 1'b0;
      hdr_pos   <= 1'b0;
    end else if (seal_evt) begin
      hdr_neg   <= cfg_structured & (neg_acc_q | ev_n);
      hdr_pos   <= cfg_structured & (pos_acc_q | ev_p);
      neg_acc_q <= 1'b0;
      pos_acc_q <= 1'b0;
    end else begin
      neg_acc_q <= neg_acc_q | ev_n;
      pos_acc_q <= pos_acc_q | ev_p;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (fill_q < cfg_len)); // R5

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sealed) |-> (hdr_ptr == PTR_NONE) || (hdr_ptr < PTR_W'(cfg_len))); // R3

  AST_NP_UNSTRUCT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sealed) && !cfg_structured) |-> (!hdr_neg && !hdr_pos)); // R6

  AST_SEAL_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |-> !store_en); // R10

endmodule

// File: rtl/vtp_emitter.sv
module vtp_emitter
  import vtp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sealed,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             hdr_rdi,
  input  logic             hdr_dba,
  input  logic             hdr_neg,
  input  logic             hdr_pos,
  input  logic [PTR_W-1:0] hdr_ptr,
  input  logic [7:0]       rd_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] rd_idx,
  output logic             release_o
);

  localparam int IDX_W = LEN_W + 1;

  logic [IDX_W-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q;
  logic [IDX_W-1:0] last_idx;
  logic             in_hdr;
  logic             xfer;
  emu_hdr_t         hdr;

  assign hdr = '{zero: 1'b0, rdi: hdr_rdi, dba: hdr_dba, neg: hdr_neg,
                 pos: hdr_pos, ptr: hdr_ptr, seq: seq_q};

  assign last_idx  = {1'b0, cfg_len} + IDX_W'(HDR_BYTES - 1);
  assign in_hdr    = (idx_q < IDX_W'(HDR_BYTES));
  assign out_valid = sealed;
  assign out_last  = sealed && (idx_q == last_idx);
  assign rd_idx    = LEN_W'(idx_q - IDX_W'(HDR_BYTES));
  assign xfer      = out_valid && out_ready;
  assign release_o = xfer && out_last;

  always_comb begin
    out_data = rd_data;
    if (in_hdr) out_data = hdr_byte(hdr, idx_q[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      seq_q <= '0;
    end else begin
      if (xfer) idx_q <= out_last ? '0 : idx_q + 1'b1;
      if (release_o) seq_q <= seq_q + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1))); // R8

  AST_SEQ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !release_o |=> $stable(seq_q)); // R8

endmodule

// File: rtl/vt_ce_packetizer.sv
module vt_ce_packetizer
  import vtp_pkg::*;
#(
  parameter int MAX_BUF = 432
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_vt_kind,
  input  logic             cfg_structured,
  input  logic [LEN_W-1:0] cfg_payload_len,
  output logic             cfg_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_mf_start,
  input  logic             in_v5,
  input  logic             evt_ptr_dec,
  input  logic             evt_ptr_inc,
  input  logic             evt_ais,
  input  logic             rdi_req,
  input  logic             dba_req,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);

  localparam int BUF_AW = (MAX_BUF > 1) ? $clog2(MAX_BUF) : 1;

  vt_kind_e         vt_kind;
  logic             cfg_ok;
  logic             beat;
  logic             byte_synced;
  logic             is_ovh;
  logic             is_v1;
  logic             sealed;
  logic             store_en;
  logic             seal_evt;
  logic             release_evt;
  logic [LEN_W-1:0] rd_idx;
  logic [7:0]       rd_data;
  logic             hdr_rdi, hdr_dba, hdr_neg, hdr_pos;
  logic [PTR_W-1:0] hdr_ptr;

  assign vt_kind  = vt_kind_e'(cfg_vt_kind);
  assign cfg_ok   = len_allowed(vt_kind, cfg_structured, cfg_payload_len, MAX_BUF);
  assign cfg_err  = !cfg_ok;
  assign in_ready = !sealed;
  assign beat     = in_valid && in_ready;

  vtp_mf_tracker u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .vt_kind     (vt_kind),
    .beat        (beat),
    .mf_start    (in_mf_start),
    .byte_synced (byte_synced),
    .is_ovh      (is_ovh),
    .is_v1       (is_v1)
  );

  vtp_collector #(.MAX_BUF(MAX_BUF), .BUF_AW(BUF_AW)) u_coll (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_structured (cfg_structured),
    .cfg_len        (cfg_payload_len),
    .cfg_ok         (cfg_ok),
    .beat           (beat),
    .in_data        (in_data),
    .byte_synced    (byte_synced),
    .is_ovh         (is_ovh),
    .is_v1          (is_v1),
    .is_v5          (in_v5),
    .ev_neg         (evt_ptr_dec),
    .ev_pos         (evt_ptr_inc),
    .ev_ais         (evt_ais),
    .rdi_req        (rdi_req),
    .dba_req        (dba_req),
    .release_i      (release_evt),
    .rd_idx         (rd_idx),
    .rd_data        (rd_data),
    .sealed         (sealed),
    .store_en       (store_en),
    .seal_evt       (seal_evt),
    .hdr_rdi        (hdr_rdi),
    .hdr_dba        (hdr_dba),
    .hdr_neg        (hdr_neg),
    .hdr_pos        (hdr_pos),
    .hdr_ptr        (hdr_ptr)
  );

  vtp_emitter u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .sealed    (sealed),
    .cfg_len   (cfg_payload_len),
    .hdr_rdi   (hdr_rdi),
    .hdr_dba   (hdr_dba),
    .hdr_neg   (hdr_neg),
    .hdr_pos   (hdr_pos),
    .hdr_ptr   (hdr_ptr),
    .rd_data   (rd_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .rd_idx    (rd_idx),
    .release_o (release_evt)
  );

  AST_PKT_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(seal_evt && beat)); // R10

  AST_ERR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !store_en); // R5

endmodule

// File: tb/vt_ce_packetizer_tb.sv
module vt_ce_packetizer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_vt_kind = 2'd0;
  logic       cfg_structured = 1'b1;
  logic [8:0] cfg_payload_len = 9'd104;
  logic       cfg_err;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'd0;
  logic       in_mf_start = 1'b0;
  logic       in_v5 = 1'b0;
  logic       evt_ptr_dec = 1'b0;
  logic       evt_ptr_inc = 1'b0;
  logic       evt_ais = 1'b0;
  logic       rdi_req = 1'b0;
  logic       dba_req = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;

  always #2 clk = ~clk;

  vt_ce_packetizer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_vt_kind(cfg_vt_kind), .cfg_structured(cfg_structured),
    .cfg_payload_len(cfg_payload_len), .cfg_err(cfg_err), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_mf_start(in_mf_start), .in_v5(in_v5),
    .evt_ptr_dec(evt_ptr_dec), .evt_ptr_inc(evt_ptr_inc), .evt_ais(evt_ais),
    .rdi_req(rdi_req), .dba_req(dba_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int seq_model = 0;
  int rdy_mode = 0;
  int outv_cnt = 0;
  string cur_tag = "R11";

  logic [31:0] exp_hdr[$];
  int          exp_len[$];
  logic [7:0]  exp_pay[$];
  logic [9:0]  stim[$];

  // table: kind, structured, length, packets, V5 position, sink readiness mode
  localparam logic [31:0] VEC [0:7] = '{
    {2'd0, 1'b1, 9'd104, 4'd3, 9'd5,   2'd0, 5'd0},
    {2'd0, 1'b0, 9'd108, 4'd2, 9'd5,   2'd0, 5'd0},
    {2'd0, 1'b1, 9'd30,  4'd5, 9'd40,  2'd1, 5'd0},
    {2'd1, 1'b0, 9'd50,  4'd4, 9'd3,   2'd2, 5'd0},
    {2'd1, 1'b1, 9'd140, 4'd2, 9'd100, 2'd1, 5'd0},
    {2'd2, 1'b1, 9'd212, 4'd2, 9'd7,   2'd2, 5'd0},
    {2'd3, 1'b0, 9'd432, 4'd2, 9'd11,  2'd0, 5'd0},
    {2'd3, 1'b1, 9'd64,  4'd3, 9'd200, 2'd1, 5'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mf_len(input int k);
    case (k)
      0: return 108;
      1: return 144;
      2: return 216;
      default: return 432;
    endcase
  endfunction

  // sink side: sets readiness, gathers packets, compares
  logic [31:0] hdr_got = '0;
  int  bcnt = 0;
  bit  pay_bad = 0;
  bit  proto_bad = 0;
  bit  prev_stall = 0;
  logic [7:0] prev_data = '0;
  int  mon_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      mon_cyc++;
      case (rdy_mode)
        1: out_ready = mon_cyc[0];
        2: out_ready = (mon_cyc % 3) == 0;
        default: out_ready = 1'b1;
      endcase
      if (out_valid) outv_cnt++;
      if (out_valid && in_ready) proto_bad = 1;
      if (prev_stall && !(out_valid && out_data == prev_data)) proto_bad = 1;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (bcnt < 4) hdr_got = {hdr_got[23:0], out_data};
        else if (exp_pay.size() == 0) pay_bad = 1;
        else if (exp_pay.pop_front() != out_data) pay_bad = 1;
        bcnt++;
        if (out_last) begin
          if (exp_hdr.size() == 0) begin
            chk(0, {cur_tag, " unexpected packet"}, 64'(hdr_got), 64'd0);
          end else begin
            logic [31:0] eh;
            int el;
            eh = exp_hdr.pop_front();
            el = exp_len.pop_front();
            chk(hdr_got == eh, {cur_tag, " header"}, 64'(hdr_got), 64'(eh));
            chk(bcnt == el + 4 && !pay_bad, {cur_tag, " payload"}, 64'(bcnt), 64'(el + 4));
            chk(!proto_bad, {cur_tag, " R10 handshake"}, 64'(proto_bad), 64'd0);
          end
          bcnt = 0;
          pay_bad = 0;
          proto_bad = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      fails++;
      checks++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 195000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive_stim();
    int i = 0;
    while (i < stim.size()) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_mf_start = stim[i][9];
      in_v5       = stim[i][8];
      in_data     = stim[i][7:0];
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_mf_start = 1'b0;
    in_v5 = 1'b0;
    stim.delete();
  endtask

  task automatic run_vector(input int vt, input bit st, input int len, input int npk,
                            input int v5pos, input int rdy, input bit r, input bit d,
                            input bit n, input bit p, input string tag);
    int mfb, q, k, pk, fill, ptr;
    @(negedge clk);
    cfg_vt_kind = 2'(vt);
    cfg_structured = st;
    cfg_payload_len = 9'(len);
    rdy_mode = rdy;
    rdi_req = r;
    dba_req = d;
    cur_tag = tag;
    mfb = mf_len(vt);
    q = mfb / 4;
    k = 0; pk = 0; fill = 0; ptr = 'h1FF;
    while (pk < npk) begin
      int pos;
      bit ovh, v1, v5;
      logic [7:0] dv;
      pos = k % mfb;
      ovh = (pos % q) == 0;
      v1  = pos == 0;
      v5  = pos == v5pos;
      dv  = 8'(k * 7 + len);
      stim.push_back({v1, v5, dv});
      if (!st || !ovh) begin
        if (ptr == 'h1FF && (st ? v5 : v1)) ptr = fill;
        exp_pay.push_back(dv);
        fill++;
        if (fill == len) begin
          bit fn, fp;
          fn = (pk == 0) && n && st;
          fp = (pk == 0) && p && st;
          exp_hdr.push_back({1'b0, r, d, fn, fp, 13'(ptr), 14'(seq_model)});
          exp_len.push_back(len);
          seq_model = (seq_model + 1) % 16384;
          pk++;
          fill = 0;
          ptr = 'h1FF;
        end
      end
      k++;
    end
    drive_stim();
    for (int w = 0; w < 4000 && exp_hdr.size() != 0; w++) @(negedge clk);
    chk(exp_hdr.size() == 0, {tag, " all packets out"}, 64'(exp_hdr.size()), 64'd0);
    rdi_req = 1'b0;
    dba_req = 1'b0;
    rdy_mode = 0;
  endtask

  task automatic raw_bytes(input int n, input bit with_mark);
    for (int i = 0; i < n; i++) stim.push_back({with_mark && (i % 108 == 0), 1'b0, 8'(i)});
    drive_stim();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_ptr_dec = 1'b1;
      1: evt_ptr_inc = 1'b1;
      default: evt_ais = 1'b1;
    endcase
    @(negedge clk);
    evt_ptr_dec = 1'b0;
    evt_ptr_inc = 1'b0;
    evt_ais = 1'b0;
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!out_valid && in_ready && !cfg_err, "R11 reset state",
        64'({out_valid, in_ready, cfg_err}), 64'({1'b0, 1'b1, 1'b0}));

    // R9 bytes before the first multiframe mark are dropped
    cur_tag = "R9";
    raw_bytes(13, 1'b0);
    repeat (10) @(negedge clk);
    chk(outv_cnt == 0, "R9 unsynced bytes dropped", 64'(outv_cnt), 64'd0);

    // table of streams: R1 R2 R3 R4 R10
    for (int v = 0; v < 8; v++) begin
      logic [31:0] e;
      e = VEC[v];
      run_vector(int'(e[31:30]), e[29], int'(e[28:20]), int'(e[19:16]), int'(e[15:7]),
                 int'(e[6:5]), 1'b0, 1'b0, 1'b0, 1'b0,
                 e[29] ? "R1 R2 R3 stream" : "R1 R2 R4 stream");
    end

    // R5 length limits
    @(negedge clk);
    cfg_vt_kind = 2'd0; cfg_structured = 1'b1; cfg_payload_len = 9'd105;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 structured 105 rejected", 64'(cfg_err), 64'd1);
    base = outv_cnt;
    cur_tag = "R5";
    raw_bytes(250, 1'b1);
    repeat (10) @(negedge clk);
    chk(outv_cnt == base, "R5 no packet while rejected", 64'(outv_cnt - base), 64'd0);
    cfg_payload_len = 9'd0;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 zero length rejected", 64'(cfg_err), 64'd1);
    cfg_vt_kind = 2'd3; cfg_payload_len = 9'd429;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 large kind 429 structured rejected", 64'(cfg_err), 64'd1);
    cfg_vt_kind = 2'd0; cfg_structured = 1'b0; cfg_payload_len = 9'd108;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R5 unstructured 108 allowed", 64'(cfg_err), 64'd0);
    run_vector(0, 1'b0, 108, 1, 3, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 limit packet");

    // R6 pointer event flags
    pulse(0);
    run_vector(0, 1'b1, 20, 1, 5, 0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 negative event");
    pulse(1);
    run_vector(0, 1'b1, 20, 1, 5, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 positive event");
    pulse(2);
    run_vector(0, 1'b1, 20, 2, 5, 1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 ais both flags");
    pulse(2);
    run_vector(0, 1'b0, 20, 1, 5, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 unstructured clears");
    run_vector(0, 1'b1, 20, 1, 5, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 nothing pending");

    // R7 remote defect and bandwidth flags
    run_vector(1, 1'b1, 33, 2, 9, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 remote defect");
    run_vector(1, 1'b0, 33, 2, 9, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R7 bandwidth flag");

    // R8 sequence wrap with one-byte packets
    run_vector(0, 1'b0, 1, 16384 - seq_model + 3, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 sequence wrap");
    chk(seq_model == 3, "R8 model wrapped", 64'(seq_model), 64'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule